// File: doc/BRIEF.md
# Interleaved Switching Clock Generator with Hysteretic Phase Shedding

This block produces the two gate-timing clocks for a two-phase interleaved boost rectifier. A programmable base period is divided into alternating halves. The first output is high for one base period and the second output is high for the next, so the pair is complementary and 180 degrees apart. Each output therefore runs at half the base switching rate. A run input starts and stops switching: with it low, both clocks are held low. With it high, switching restarts from the first output.

A load-power code drives a shedding controller with hysteresis. The code is unsigned, with rated power at full scale. When the code stays below a programmable low threshold for a programmable number of output periods, one phase is turned off. Any higher reading restarts the wait. When the code goes above a separate high threshold, both phases are turned back on. Each time single-phase operation is entered, the phase that carries the load swaps, so that over time both channels share the thermal stress. Mode and phase changes take effect only where an output period begins, so no shortened pulse is ever produced.

Top module: `ph_clk_shed`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `clk_a_o`, `clk_b_o`, `single_o` and `act_b_o` are all 0. After reset the first single-phase entry selects channel B.
- R2: When `en_i` is sampled low, both clock outputs are 0 from the next cycle onward. The cycle after `en_i` is first sampled high, the base period begins with channel A's half (phase bit 0).
- R3: A base period lasts `per_i`+1 clock cycles. In dual mode, `clk_a_o` is high for one whole base period and `clk_b_o` is high for the following one, so the two are never high together.
- R4: `per_i` is captured only while stopped or at the last cycle of a base period. A change therefore takes effect at the next base-period boundary.
- R5: An output-period boundary is the last cycle of channel B's half. At each boundary where `pwr_i` < `thr_lo_i`, a run counter advances. If the run counter plus one is at least `hold_i`, the block enters single mode at that boundary. A `hold_i` of 0 or 1 sheds at the first qualifying boundary.
- R6: Any cycle with `pwr_i` >= `thr_lo_i` clears the run counter. A reading equal to the low threshold does not count as low.
- R7: In single mode, any cycle with `pwr_i` > `thr_hi_i` latches a restore request. Dual mode resumes at the next output-period boundary, even if the power has fallen back by then.
- R8: `act_b_o` (0 = channel A, 1 = channel B) inverts on every entry into single mode and holds its value at all other times.
- R9: In single mode, only the selected channel pulses, in its own half of the output period. The other channel stays at 0.
- R10: Both threshold compares are strict. A reading equal to `thr_hi_i` does not restore dual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds both outputs low |
| per_i | input | DIV_W | Base period length minus one, in clock cycles |
| pwr_i | input | PWR_W | Load power code, rated power at full scale |
| thr_lo_i | input | PWR_W | Shed threshold (strictly below sheds) |
| thr_hi_i | input | PWR_W | Restore threshold (strictly above restores) |
| hold_i | input | HOLD_W | Low-power output periods needed before shedding |
| clk_a_o | output | 1 | Switching clock for channel A |
| clk_b_o | output | 1 | Switching clock for channel B |
| single_o | output | 1 | 1 while one phase is shed |
| act_b_o | output | 1 | Channel carrying the load in single mode (1 = B) |

## Verification
The bench probes several edge cases:
- A power reading exactly at either threshold. A design using non-strict compares would shed or restore one condition too early.
- One-cycle excursions back to the low threshold part-way through a shed wait. A design that only samples at boundaries would shed anyway.
- A restore pulse that is gone before the boundary. A design without the latched request would miss it.
- Period values changed mid-period, including a one-cycle period. A design that applies them at once would produce truncated pulses.
- Repeated shed and restore cycles with a zero hold. If the phase does not swap on each entry, or swaps when it should not, the selected channel diverges from the expected one.

// File: rtl/ph_clk_shed_pkg.sv
package ph_clk_shed_pkg;

    typedef enum logic {
        MODE_DUAL   = 1'b0,
        MODE_SINGLE = 1'b1
    } shed_mode_e;

    typedef struct packed {
        logic run;      // switching active this cycle
        logic ph;       // 0: channel A half, 1: channel B half
        logic base_end; // last cycle of a base period
        logic out_end;  // last cycle of an output period (end of B half)
    } tick_t;

    // Gate a channel given timing and shedding state.
    function automatic logic gate_phase(input tick_t tk, input shed_mode_e mode,
                                        input logic act_b, input logic chan_b);
        logic own_half;
        logic allowed;
        own_half = chan_b ? tk.ph : ~tk.ph;
        allowed  = (mode == MODE_DUAL) || (act_b == chan_b);
        return tk.run & own_half & allowed;
    endfunction

endpackage

// File: rtl/ph_clk_timebase.sv
module ph_clk_timebase
    import ph_clk_shed_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] per_i,
    output tick_t            tk_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] per_q;
    logic             ph_q;
    logic             run_q;
    logic             last_w;

    assign last_w = run_q && en_i && (div_q == per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            per_q <= '0;
            ph_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            run_q <= en_i;
            if (!en_i || !run_q) begin
                div_q <= '0;
                ph_q  <= 1'b0;
                per_q <= per_i;
            end else if (last_w) begin
                div_q <= '0;
                ph_q  <= ~ph_q;
                per_q <= per_i;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    always_comb begin
        tk_o.run      = run_q;
        tk_o.ph       = ph_q;
        tk_o.base_end = last_w;
        tk_o.out_end  = last_w && ph_q;
    end
endmodule

// File: rtl/ph_clk_shed_ctrl.sv
module ph_clk_shed_ctrl
    import ph_clk_shed_pkg::*;
#(
    parameter int PWR_W  = 10,
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              out_end_i,
    input  logic [PWR_W-1:0]  pwr_i,
    input  logic [PWR_W-1:0]  thr_lo_i,
    input  logic [PWR_W-1:0]  thr_hi_i,
    input  logic [HOLD_W-1:0] hold_i,
    output shed_mode_e        mode_o,
    output logic              act_b_o
);
    localparam logic [HOLD_W:0] CNT_MAX = {1'b0, {HOLD_W{1'b1}}};

    shed_mode_e      mode_q;
    logic            act_b_q;
    logic            req_q;
    logic [HOLD_W:0] run_cnt_q;
    logic [HOLD_W:0] cnt_inc_w;
    logic            low_w;
    logic            high_w;
    logic            shed_w;
    logic            rest_w;

    assign low_w     = pwr_i < thr_lo_i;
    assign high_w    = pwr_i > thr_hi_i;
    assign cnt_inc_w = run_cnt_q + 1'b1;
    assign shed_w    = out_end_i && (mode_q == MODE_DUAL) && low_w
                       && (cnt_inc_w >= {1'b0, hold_i});
    assign rest_w    = out_end_i && (mode_q == MODE_SINGLE) && (req_q || high_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_DUAL;
            act_b_q   <= 1'b0;
            req_q     <= 1'b0;
            run_cnt_q <= '0;
        end else begin
            if (!low_w || shed_w || rest_w) begin
                run_cnt_q <= '0;
            end else if (out_end_i && run_cnt_q != CNT_MAX) begin
                run_cnt_q <= cnt_inc_w;
            end

            if (mode_q != MODE_SINGLE || rest_w) begin
                req_q <= 1'b0;
            end else if (high_w) begin
                req_q <= 1'b1;
            end

            if (shed_w) begin
                mode_q  <= MODE_SINGLE;
                act_b_q <= ~act_b_q;
            end else if (rest_w) begin
                mode_q  <= MODE_DUAL;
            end
        end
    end

    assign mode_o  = mode_q;
    assign act_b_o = act_b_q;
endmodule

// File: rtl/ph_clk_shed.sv
module ph_clk_shed
    import ph_clk_shed_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int PWR_W  = 10,
    parameter int HOLD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  per_i,
    input  logic [PWR_W-1:0]  pwr_i,
    input  logic [PWR_W-1:0]  thr_lo_i,
    input  logic [PWR_W-1:0]  thr_hi_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              clk_a_o,
    output logic              clk_b_o,
    output logic              single_o,
    output logic              act_b_o
);
    localparam int NCH = 2;

    tick_t      tk_w;
    shed_mode_e mode_w;
    logic       act_b_w;
    logic [NCH-1:0] gate_w;

    ph_clk_timebase #(.DIV_W(DIV_W)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .en_i (en_i),
        .per_i(per_i),
        .tk_o (tk_w)
    );

    ph_clk_shed_ctrl #(.PWR_W(PWR_W), .HOLD_W(HOLD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .out_end_i(tk_w.out_end),
        .pwr_i    (pwr_i),
        .thr_lo_i (thr_lo_i),
        .thr_hi_i (thr_hi_i),
        .hold_i   (hold_i),
        .mode_o   (mode_w),
        .act_b_o  (act_b_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign gate_w[c] = gate_phase(tk_w, mode_w, act_b_w, c[0]);
    end

    assign clk_a_o  = gate_w[0];
    assign clk_b_o  = gate_w[1];
    assign single_o = (mode_w == MODE_SINGLE);
    assign act_b_o  = act_b_w;
endmodule

// File: rtl/ph_clk_shed_chk.sv
module ph_clk_shed_chk #(
    parameter int PWR_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic [PWR_W-1:0] pwr_i,
    input logic [PWR_W-1:0] thr_lo_i,
    input logic             clk_a_o,
    input logic             clk_b_o,
    input logic             single_o,
    input logic             act_b_o
);
    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(clk_a_o && clk_b_o));                                        // R3

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!clk_a_o && !clk_b_o));                             // R2

    AST_SHED_OFF_CHAN: assert property (@(posedge clk) disable iff (rst)
        single_o |-> !(act_b_o ? clk_a_o : clk_b_o));                  // R9

    AST_SWAP_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(single_o) |-> (act_b_o != $past(act_b_o)));              // R8

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
        !$rose(single_o) |-> $stable(act_b_o));                        // R8

    AST_NO_SHED_AT_LO: assert property (@(posedge clk) disable iff (rst)
        (!single_o && pwr_i >= thr_lo_i) |=> !single_o);               // R6
endmodule

bind ph_clk_shed ph_clk_shed_chk #(.PWR_W(PWR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .pwr_i   (pwr_i),
    .thr_lo_i(thr_lo_i),
    .clk_a_o (clk_a_o),
    .clk_b_o (clk_b_o),
    .single_o(single_o),
    .act_b_o (act_b_o)
);

// File: tb/ph_clk_shed_tb.sv
module ph_clk_shed_tb;
    localparam int DIV_W  = 16;
    localparam int PWR_W  = 10;
    localparam int HOLD_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_i = 1'b0;
    logic [DIV_W-1:0]  per_i = 16'd3;
    logic [PWR_W-1:0]  pwr_i = 10'd900;
    logic [PWR_W-1:0]  thr_lo_i = 10'd400;
    logic [PWR_W-1:0]  thr_hi_i = 10'd460;
    logic [HOLD_W-1:0] hold_i = 12'd3;
    logic clk_a_o, clk_b_o, single_o, act_b_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string tag   = "R1";
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ph_clk_shed #(.DIV_W(DIV_W), .PWR_W(PWR_W), .HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .per_i(per_i), .pwr_i(pwr_i),
        .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i), .hold_i(hold_i),
        .clk_a_o(clk_a_o), .clk_b_o(clk_b_o), .single_o(single_o), .act_b_o(act_b_o)
    );

    // Behavioural expectation built from the requirement text.
    bit        m_run, m_ph, m_single, m_act, m_req;
    int        m_div, m_per, m_lowcnt;

    function automatic bit exp_a();
        return m_run && !m_ph && (!m_single || !m_act);
    endfunction
    function automatic bit exp_b();
        return m_run && m_ph && (!m_single || m_act);
    endfunction

    always @(posedge clk) begin
        bit last, bnd, low, high, shed, back;
        if (rst) begin
            m_run = 0; m_ph = 0; m_single = 0; m_act = 0; m_req = 0;
            m_div = 0; m_per = 0; m_lowcnt = 0;
        end else begin
            last = m_run && en_i && (m_div == m_per);
            bnd  = last && m_ph;
            low  = pwr_i < thr_lo_i;
            high = pwr_i > thr_hi_i;
            shed = bnd && !m_single && low && (m_lowcnt + 1 >= int'(hold_i));
            back = bnd && m_single && (m_req || high);
            if (!low || shed || back) m_lowcnt = 0;
            else if (bnd && m_lowcnt < 4095) m_lowcnt++;
            if (!m_single || back) m_req = 0;
            else if (high) m_req = 1;
            if (shed) begin m_single = 1; m_act = !m_act; end
            else if (back) m_single = 0;
            if (!en_i || !m_run) begin m_div = 0; m_ph = 0; m_per = int'(per_i); end
            else if (last) begin m_div = 0; m_ph = !m_ph; m_per = int'(per_i); end
            else m_div++;
            m_run = en_i;
        end
    end

    task automatic chk(input bit got, input bit exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %0b expected %0b at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            // R1: reset state
            chk(clk_a_o, 1'b0, "R1 clk_a_o in reset");
            chk(clk_b_o, 1'b0, "R1 clk_b_o in reset");
            chk(single_o, 1'b0, "R1 single_o in reset");
            chk(act_b_o, 1'b0, "R1 act_b_o in reset");
        end else if (!done) begin
            chk(clk_a_o, exp_a(), "clk_a_o");
            chk(clk_b_o, exp_b(), "clk_b_o");
            chk(single_o, m_single, "single_o");
            chk(act_b_o, m_act, "act_b_o");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired expected finish before cycle 150000 got %0d", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        tag = "R1"; step(2);

        tag = "R3"; en_i = 1'b1; step(40);
        tag = "R4"; per_i = 16'd5; step(3); per_i = 16'd0; step(9); per_i = 16'd5; step(40);

        tag = "R2"; en_i = 1'b0; step(10);
        chk(clk_a_o | clk_b_o, 1'b0, "R2 outputs while stopped");
        en_i = 1'b1; step(1);
        chk(clk_a_o, 1'b1, "R2 channel A first after start");
        step(20);

        tag = "R6"; pwr_i = 10'd100;
        for (int k = 0; k < 8; k++) begin
            step(18); pwr_i = 10'd400; step(1); pwr_i = 10'd100;
        end
        chk(single_o, 1'b0, "R6 no shed with reading at low threshold");
        pwr_i = 10'd900; step(5);

        tag = "R5"; pwr_i = 10'd100; step(60);
        chk(single_o, 1'b1, "R5 shed after hold periods");
        chk(act_b_o, 1'b1, "R1 first entry selects channel B");

        tag = "R10"; pwr_i = 10'd460; step(40);
        chk(single_o, 1'b1, "R10 stays single at high threshold");

        tag = "R7"; pwr_i = 10'd470; step(1); pwr_i = 10'd430; step(30);
        chk(single_o, 1'b0, "R7 restored by latched request");

        tag = "R8"; hold_i = 12'd0;
        for (int k = 0; k < 4; k++) begin
            pwr_i = 10'd50; step(30);
            pwr_i = 10'd800; step(30);
        end

        tag = "R9";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 12) pwr_i = PWR_W'($urandom_range(0, 1023));
            else if (r < 14) per_i = DIV_W'($urandom_range(0, 4));
            else if (r < 15) en_i = !en_i;
            else if (r < 16) hold_i = HOLD_W'($urandom_range(0, 4));
            else if (r < 18) pwr_i = (r[0]) ? thr_lo_i : thr_hi_i;
            if (!en_i && r > 90) en_i = 1'b1;
            step(1);
        end

        done = 1'b1;
        step(1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule